// File: doc/BRIEF.md
# Dual-Speed I2C Clock Timing Generator

This block produces the serial clock of an I2C controller. It keeps two pairs of period counts, one for standard rate and one for fast rate, and a rate-select input picks the pair in use. While the generator runs, it alternates between a phase in which it pulls the clock line low and a phase in which it releases the line. Each phase has a fixed overhead added to its programmed count. The low phase is timed from the moment the block starts pulling. The released phase is timed only once the sensed line has actually gone high, so a slave that stretches the clock or a slow bus rise lengthens the period instead of shortening the high time.

Inside each low phase the block issues a one-cycle data-update strobe a programmable number of cycles after the clock falls. The surrounding controller uses this strobe as the moment to change the data line. The configuration is captured only while the generator is stopped, so software may rewrite it at any time without disturbing a running clock. Start and stop conditions and the shifting of bytes belong to the surrounding controller. The ports are plain control and status signals, with no streaming handshake.

Top module: `scl_timing_gen`

## Requirements
- R1: While `gen_en` is low, and during reset, `scl_pull_low` and `sda_update` are both 0 whatever the value of `scl_sense`.
- R2: The first clock edge that sees `gen_en` high starts a low phase. A low phase holds `scl_pull_low` at 1 for exactly L+1 cycles, where L is the selected low count, and it ignores `scl_sense`.
- R3: `fast_mode`=1 selects `fast_high_cnt`/`fast_low_cnt`, and `fast_mode`=0 selects `std_high_cnt`/`std_low_cnt`.
- R4: When the line reads high from the first released cycle, `scl_pull_low` stays 0 for exactly H+8 cycles, where H is the selected high count, and then a new low phase begins.
- R5: The high count advances only from the first released cycle in which `scl_sense` is sampled 1. If the line reads low for W released cycles, the released phase lasts W+H+8 cycles.
- R6: `sda_update` pulses exactly once per low phase, for one cycle, and only while `scl_pull_low` is 1. The pulse comes in the low cycle with index D, where index 0 is the first low cycle and D is `sda_hold_cnt`.
- R7: A `sda_hold_cnt` of 0 behaves as 1, so the pulse comes in low-cycle index 1, or in index 0 when L=0 (see R8).
- R8: When the hold index exceeds L, the pulse comes in the last low cycle, index L.
- R9: The counts, the hold value and `fast_mode` are captured on every clock edge while the generator is stopped. Changes made while it runs have no effect until it has been stopped and restarted.
- R10: When `gen_en` is sampled low, `scl_pull_low` and `sda_update` are 0 from the following cycle on, whatever the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_en | input | 1 | Run the clock generator |
| fast_mode | input | 1 | 1 selects the fast count pair |
| std_high_cnt | input | CNT_W | Standard-rate high count |
| std_low_cnt | input | CNT_W | Standard-rate low count |
| fast_high_cnt | input | CNT_W | Fast-rate high count |
| fast_low_cnt | input | CNT_W | Fast-rate low count |
| sda_hold_cnt | input | HOLD_W | Cycles from clock fall to the data-update strobe |
| scl_sense | input | 1 | Sensed level of the clock line |
| scl_pull_low | output | 1 | 1 drives the clock line low |
| sda_update | output | 1 | One-cycle strobe marking the data change point |

## Verification
The hardest case to reach is a released phase in which the line stays low after the block lets go. The open-drain model in the bench forms the sensed line as the inverse of the pull output, ANDed with a stretch flag. For a chosen number of released cycles the bench holds that flag, which delays the start of the high count. The second hard case is a rewrite of the counts in the middle of a running clock. The bench makes that change between two measured periods and expects the period to stay the same, and it expects the new values only after a stop and restart. It also drives a zero hold and a hold larger than the low phase, including a single-cycle low phase.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // Fixed cycles added on top of the programmed counts.
  localparam int LOW_EXTRA  = 1;
  localparam int HIGH_EXTRA = 8;
endpackage

// File: rtl/sclgen_cfg_shadow.sv
module sclgen_cfg_shadow #(
  parameter int CNT_W      = 16,
  parameter int HOLD_W     = 16,
  parameter int NUM_SPEEDS = 2,
  localparam int SEL_W     = (NUM_SPEEDS > 1) ? $clog2(NUM_SPEEDS) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             load,
  input  logic [SEL_W-1:0]                 speed_sel,
  input  logic [NUM_SPEEDS-1:0][CNT_W-1:0] high_tab,
  input  logic [NUM_SPEEDS-1:0][CNT_W-1:0] low_tab,
  input  logic [HOLD_W-1:0]                hold_in,
  output logic [CNT_W-1:0]                 high_q,
  output logic [CNT_W-1:0]                 low_q,
  output logic [HOLD_W-1:0]                hold_q
);
  logic [CNT_W-1:0] high_pick, low_pick;

  always_comb begin
    high_pick = high_tab[0];
    low_pick  = low_tab[0];
    for (int i = 1; i < NUM_SPEEDS; i++) begin
      if (speed_sel == SEL_W'(i)) begin
        high_pick = high_tab[i];
        low_pick  = low_tab[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_q <= '0;
      low_q  <= '0;
      hold_q <= '0;
    end else if (load) begin
      high_q <= high_pick;
      low_q  <= low_pick;
      hold_q <= hold_in;
    end
  end

  // R9: captured settings stay frozen while the generator runs.
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(high_q) && $stable(low_q) && $stable(hold_q)));
endmodule

// File: rtl/sclgen_phase_fsm.sv
module sclgen_phase_fsm
  import sclgen_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CW    = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             scl_in,
  input  logic [CNT_W-1:0] high_cnt,
  input  logic [CNT_W-1:0] low_cnt,
  output phase_e           phase,
  output logic [CW-1:0]    cnt,
  output logic             pull_low
);
  logic          seen_high;
  logic [CW-1:0] low_last, high_last;
  logic          high_counting;

  assign low_last      = CW'(low_cnt) + CW'(LOW_EXTRA - 1);
  assign high_last     = CW'(high_cnt) + CW'(HIGH_EXTRA - 1);
  assign high_counting = seen_high || scl_in;
  assign pull_low      = (phase == PH_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      seen_high <= 1'b0;
    end else if (!run) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      seen_high <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          phase <= PH_LOW;
          cnt   <= '0;
        end
        PH_LOW: begin
          if (cnt == low_last) begin
            phase     <= PH_HIGH;
            cnt       <= '0;
            seen_high <= 1'b0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        PH_HIGH: begin
          if (high_counting) begin
            seen_high <= 1'b1;
            if (cnt == high_last) begin
              phase <= PH_LOW;
              cnt   <= '0;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  // R5: a line held low before the first high sample keeps the count at zero.
  p_stretch_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase == PH_HIGH && !seen_high && !scl_in) |=> (phase == PH_HIGH && cnt == '0));

  // R2: the low count never passes its end value.
  p_low_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOW) |-> (cnt <= low_last));

  // R10: a stop request returns the generator to idle on the next edge.
  p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (phase == PH_IDLE));
endmodule

// File: rtl/sclgen_hold_strobe.sv
module sclgen_hold_strobe
  import sclgen_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int HOLD_W = 16,
  parameter int CW     = CNT_W + 2
) (
  input  phase_e            phase,
  input  logic [CW-1:0]     cnt,
  input  logic [CNT_W-1:0]  low_cnt,
  input  logic [HOLD_W-1:0] hold,
  output logic              strobe
);
  logic [CW-1:0] hold_eff, last_low_idx, target;

  assign last_low_idx = CW'(low_cnt) + CW'(LOW_EXTRA - 1);
  assign hold_eff     = (hold == '0) ? CW'(1) : CW'(hold);
  assign target       = (hold_eff > last_low_idx) ? last_low_idx : hold_eff;
  assign strobe       = (phase == PH_LOW) && (cnt == target);
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import sclgen_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_en,
  input  logic              fast_mode,
  input  logic [CNT_W-1:0]  std_high_cnt,
  input  logic [CNT_W-1:0]  std_low_cnt,
  input  logic [CNT_W-1:0]  fast_high_cnt,
  input  logic [CNT_W-1:0]  fast_low_cnt,
  input  logic [HOLD_W-1:0] sda_hold_cnt,
  input  logic              scl_sense,
  output logic              scl_pull_low,
  output logic              sda_update
);
  localparam int CW     = ((CNT_W > HOLD_W) ? CNT_W : HOLD_W) + 2;
  localparam int SPEEDS = 2;

  phase_e                         phase;
  logic [CW-1:0]                  cnt;
  logic [CNT_W-1:0]               high_q, low_q;
  logic [HOLD_W-1:0]              hold_q;
  logic [SPEEDS-1:0][CNT_W-1:0]   high_tab, low_tab;

  assign high_tab = {fast_high_cnt, std_high_cnt};
  assign low_tab  = {fast_low_cnt, std_low_cnt};

  sclgen_cfg_shadow #(
    .CNT_W(CNT_W), .HOLD_W(HOLD_W), .NUM_SPEEDS(SPEEDS)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(phase == PH_IDLE),
    .speed_sel(fast_mode), .high_tab(high_tab), .low_tab(low_tab),
    .hold_in(sda_hold_cnt), .high_q(high_q), .low_q(low_q), .hold_q(hold_q)
  );

  sclgen_phase_fsm #(.CNT_W(CNT_W), .CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .run(gen_en), .scl_in(scl_sense),
    .high_cnt(high_q), .low_cnt(low_q),
    .phase(phase), .cnt(cnt), .pull_low(scl_pull_low)
  );

  sclgen_hold_strobe #(.CNT_W(CNT_W), .HOLD_W(HOLD_W), .CW(CW)) u_hold (
    .phase(phase), .cnt(cnt), .low_cnt(low_q), .hold(hold_q), .strobe(sda_update)
  );

  // Checker state: strobes seen in the current low phase.
  logic strobe_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             strobe_seen <= 1'b0;
    else if (!scl_pull_low) strobe_seen <= 1'b0;
    else if (sda_update)    strobe_seen <= 1'b1;
  end

  // R6: the strobe only occurs while the clock is pulled low.
  p_strobe_in_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sda_update |-> scl_pull_low);

  // R6: at most one strobe per low phase.
  p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sda_update |-> !strobe_seen);

  // R1: idle means both outputs quiet.
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> (!scl_pull_low && !sda_update));

  // R10: stop releases the line on the next cycle.
  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> (!scl_pull_low && !sda_update));
endmodule

// File: tb/scl_timing_gen_tb_top.sv
`timescale 1ns/1ps
module scl_timing_gen_tb_top;
  localparam int CNT_W  = 16;
  localparam int HOLD_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gen_en = 1'b0, fast_mode = 1'b0;
  logic [CNT_W-1:0] std_high_cnt = '0, std_low_cnt = '0, fast_high_cnt = '0, fast_low_cnt = '0;
  logic [HOLD_W-1:0] sda_hold_cnt = '0;
  logic stretch = 1'b0;
  logic scl_pull_low, sda_update, scl_sense;

  always #5 clk = ~clk;

  // Open-drain line: low when the block pulls or a slave stretches.
  assign scl_sense = !scl_pull_low && !stretch;

  scl_timing_gen #(.CNT_W(CNT_W), .HOLD_W(HOLD_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .fast_mode(fast_mode),
    .std_high_cnt(std_high_cnt), .std_low_cnt(std_low_cnt),
    .fast_high_cnt(fast_high_cnt), .fast_low_cnt(fast_low_cnt),
    .sda_hold_cnt(sda_hold_cnt), .scl_sense(scl_sense),
    .scl_pull_low(scl_pull_low), .sda_update(sda_update)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // Behavioural reference: state 0 stopped, 1 pulling low, 2 released.
  int m_st = 0, m_cnt = 0, m_hi = 0, m_lo = 0, m_hold = 0;
  bit m_seen = 0;

  function automatic int strobe_idx(int lo, int hold);
    int d;
    d = (hold == 0) ? 1 : hold;
    return (d > lo) ? lo : d;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_seen = 0; m_hi = 0; m_lo = 0; m_hold = 0;
    end else begin
      if (m_st == 0) begin
        m_hi   = fast_mode ? int'(fast_high_cnt) : int'(std_high_cnt);
        m_lo   = fast_mode ? int'(fast_low_cnt) : int'(std_low_cnt);
        m_hold = int'(sda_hold_cnt);
      end
      if (!gen_en) begin
        m_st = 0; m_cnt = 0; m_seen = 0;
      end else if (m_st == 0) begin
        m_st = 1; m_cnt = 0;
      end else if (m_st == 1) begin
        if (m_cnt == m_lo) begin m_st = 2; m_cnt = 0; m_seen = 0; end
        else m_cnt++;
      end else begin
        if (m_seen || scl_sense) begin
          m_seen = 1;
          if (m_cnt == m_hi + 7) begin m_st = 1; m_cnt = 0; end
          else m_cnt++;
        end
      end
    end
  end

  // Per-clock comparison against the reference.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_pull, exp_upd;
      exp_pull = (m_st == 1);
      exp_upd  = (m_st == 1) && (m_cnt == strobe_idx(m_lo, m_hold));
      n_vec++;
      if (scl_pull_low !== exp_pull) begin
        n_bad++;
        $display("FAIL %s pull: actual %0b expected %0b at %0t",
                 (m_st == 0) ? "R10" : ((m_st == 1) ? "R2" : "R4"), scl_pull_low, exp_pull, $time);
      end
      if (sda_update !== exp_upd) begin
        n_bad++;
        $display("FAIL R6 strobe: actual %0b expected %0b at %0t", sda_update, exp_upd, $time);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Called at a negedge; measures one full low+high period.
  task automatic measure(input int w, output int lo, output int hi,
                         output int sidx, output int scount);
    while (!scl_pull_low) @(negedge clk);
    lo = 0; sidx = -1; scount = 0;
    while (scl_pull_low) begin
      if (sda_update) begin scount++; sidx = lo; end
      lo++;
      @(negedge clk);
    end
    hi = 0;
    while (!scl_pull_low) begin
      hi++;
      stretch = (hi <= w);
      @(negedge clk);
    end
    stretch = 1'b0;
  endtask

  task automatic stop_gen();
    gen_en = 1'b0;
    @(negedge clk);
    check("R10 pull after stop", int'(scl_pull_low), 0);
    check("R10 strobe after stop", int'(sda_update), 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int lo, hi, si, sc;
    repeat (3) @(negedge clk);
    check("R1 pull in reset", int'(scl_pull_low), 0);
    check("R1 strobe in reset", int'(sda_update), 0);
    rst_n = 1'b1;
    std_high_cnt = 3; std_low_cnt = 5; sda_hold_cnt = 2;
    fast_high_cnt = 1; fast_low_cnt = 2;
    repeat (3) @(negedge clk);
    check("R1 idle pull", int'(scl_pull_low), 0);
    gen_en = 1'b1;
    @(negedge clk);
    check("R2 low starts after enable", int'(scl_pull_low), 1);

    measure(0, lo, hi, si, sc);
    check("R2 low length", lo, 6);
    check("R4 high length", hi, 11);
    check("R6 strobe index", si, 2);
    check("R6 strobe count", sc, 1);

    measure(5, lo, hi, si, sc);
    check("R5 stretched high length", hi, 16);
    check("R2 low length after stretch", lo, 6);

    // R9: rewrite while running.
    std_low_cnt = 9; std_high_cnt = 0; sda_hold_cnt = 0; fast_mode = 1'b1;
    measure(0, lo, hi, si, sc);
    check("R9 low unchanged", lo, 6);
    check("R9 high unchanged", hi, 11);
    check("R9 strobe unchanged", si, 2);
    stop_gen();

    // R3 fast pair, R7 zero hold.
    gen_en = 1'b1;
    measure(0, lo, hi, si, sc);
    check("R3 fast low length", lo, 3);
    check("R3 fast high length", hi, 9);
    check("R7 zero hold index", si, 1);
    stop_gen();

    // R8 clamp, standard pair with new values.
    fast_mode = 1'b0; sda_hold_cnt = 20;
    @(negedge clk);
    gen_en = 1'b1;
    measure(0, lo, hi, si, sc);
    check("R9 new low after restart", lo, 10);
    check("R4 high length H=0", hi, 8);
    check("R8 clamped strobe index", si, 9);
    check("R6 strobe count clamp", sc, 1);
    stop_gen();

    // R8 single-cycle low with zero hold.
    fast_mode = 1'b1; fast_low_cnt = 0; sda_hold_cnt = 0;
    @(negedge clk);
    gen_en = 1'b1;
    measure(0, lo, hi, si, sc);
    check("R8 one-cycle low length", lo, 1);
    check("R8 one-cycle strobe index", si, 0);
    measure(2, lo, hi, si, sc);
    check("R5 stretched fast high", hi, 11);
    gen_en = 1'b0;
    @(negedge clk);
    check("R10 stop mid-period", int'(scl_pull_low), 0);
    repeat (4) @(negedge clk);
    check("R1 stays idle", int'(scl_pull_low) + int'(sda_update), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule